// File: doc/BRIEF.md
# Effective Address Quadrant Qualifier

This block sits at the front of a two-stage address translation path. On each request strobe it looks at a 64-bit effective address, the hypervisor-mode and relocation flags, and the kind of access. It then returns the partition and process identifiers that the later table walk should use. An address can also be illegal: a reserved bit may be set, or a guest may reach into a quadrant kept for the hypervisor. In that case the block raises a segment fault and builds a fault record. The record holds the exception class, a captured data address and an error-code clear.

The two most significant address bits pick one of four quadrants. In each quadrant the partition and process identifiers are either taken from their registers or forced to zero, and hypervisor mode and guest mode use different tables. When relocation is off in hypervisor mode, no identifiers are produced. Instead the block forms a real address directly and grants full permissions at the base page size. When relocation is off in guest mode, the address is passed on for a partition-only translation.

All results are registered one cycle after the strobe, alongside a single-cycle done pulse. They hold until the next strobe.

Top module: `eaq_qualifier`

## Requirements
- R1: With relocation on, a nonzero value in any of address bits 61 down to 52 (bit 63 is the most significant) raises a segment fault, and no identifiers are produced.
- R2: In hypervisor mode with relocation on, the quadrant (address bits 63:62) gives these results. Quadrant 0 yields partition 0 and the process register. Quadrant 1 yields both registers. Quadrant 2 yields the partition register and process 0. Quadrant 3 yields zero for both.
- R3: In guest mode with relocation on, quadrant 0 yields both registers and quadrant 3 yields the partition register with process 0. Quadrants 1 and 2 raise a segment fault, with id_valid low and both identifiers zero.
- R4: The access type is encoded 00 load, 01 store, 10 fetch and 11 reserved, which behaves as a load. On a fault, a fetch gives exception class 1 (instruction segment) and every other access type gives class 2 (data segment). Class 0 means no fault.
- R5: A data-segment fault captures the effective address into fault_dar. Any other request leaves fault_dar unchanged.
- R6: err_clr is high exactly when the registered result is a segment fault.
- R7: In hypervisor mode with relocation off, real_addr is the address with bits 63:60 cleared. If bit 63 of the address is 0, rm_offset is ORed into the result.
- R8: A hypervisor real-mode result sets real_mode, perm_rwx = 3'b111 and page_shift = PAGE_SHIFT, and it never faults, even with reserved bits set. Every other result has perm_rwx and page_shift at zero.
- R9: In guest mode with relocation off, the result never faults. It sets part_only and id_valid, passes the partition register with process 0, and gives real_addr as the address with bits 63:60 cleared.
- R10: done is high for exactly the one cycle after each request. All result outputs hold their values until the next request.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe |
| ea | input | ADDR_W | Effective address |
| hv_mode | input | 1 | Hypervisor mode flag |
| reloc | input | 1 | Relocation enabled |
| acc | input | 2 | Access type: 00 load, 01 store, 10 fetch, 11 as load |
| lpid_reg | input | LPID_W | Partition ID register |
| pid_reg | input | PID_W | Process ID register |
| rm_offset | input | ADDR_W | Real-mode offset register |
| done | output | 1 | One-cycle completion pulse |
| id_valid | output | 1 | Identifiers are valid |
| lpid_o | output | LPID_W | Qualified partition ID |
| pid_o | output | PID_W | Qualified process ID |
| real_mode | output | 1 | Result is a hypervisor real-mode address |
| part_only | output | 1 | Guest address passed for partition-only translation |
| real_addr | output | ADDR_W | Real or pass-through address |
| perm_rwx | output | 3 | Read, write, execute permissions (real mode) |
| page_shift | output | PS_W | Page size as log2 (real mode) |
| seg_fault | output | 1 | Segment fault raised |
| exc_class | output | 2 | 0 none, 1 instruction segment, 2 data segment |
| fault_dar | output | ADDR_W | Captured data address |
| err_clr | output | 1 | Error code cleared with the fault |

## Verification
The bench builds the block with LPID_W = 8 and PID_W = 16 and keeps the 64-bit address and the 12-bit base page shift. At these narrower identifier widths, random register values often reach all-ones and all-zeros. That shows whether each quadrant passes the register or forces zero. Directed cases also set the lowest and highest reserved address bits one at a time. Together with mixed access types, these reach both fault classes and the rule that the captured data address must survive fetch faults.

// File: rtl/eaq_pkg.sv
package eaq_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_ISEG = 2'd1,
    EXC_DSEG = 2'd2
  } exc_e;

  localparam int RSVD_BITS = 10;
  localparam int TOP_CLR   = 4;
endpackage

// File: rtl/eaq_decode.sv
module eaq_decode import eaq_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic              hv_mode,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic              legal,
  output logic [LPID_W-1:0] lpid,
  output logic [PID_W-1:0]  pid
);
  logic [1:0] quad;
  logic       rsvd_hit;
  logic       use_lp, use_pd, quad_ok;

  assign quad     = ea[ADDR_W-1 -: 2];
  assign rsvd_hit = |ea[ADDR_W-3 -: RSVD_BITS];

  always_comb begin
    use_lp  = 1'b0;
    use_pd  = 1'b0;
    quad_ok = 1'b1;
    if (hv_mode) begin
      unique case (quad)
        2'd0: use_pd = 1'b1;
        2'd1: begin use_lp = 1'b1; use_pd = 1'b1; end
        2'd2: use_lp = 1'b1;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin use_lp = 1'b1; use_pd = 1'b1; end
        2'd3: use_lp = 1'b1;
        default: quad_ok = 1'b0;
      endcase
    end
  end

  assign legal = quad_ok && !rsvd_hit;
  assign lpid  = (legal && use_lp) ? lpid_reg : '0;
  assign pid   = (legal && use_pd) ? pid_reg  : '0;
endmodule

// File: rtl/eaq_realmode.sv
module eaq_realmode import eaq_pkg::*; #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] rm_offset,
  output logic [ADDR_W-1:0] masked,
  output logic [ADDR_W-1:0] raddr
);
  function automatic logic [ADDR_W-1:0] clr_top(input logic [ADDR_W-1:0] a);
    return {{TOP_CLR{1'b0}}, a[ADDR_W-TOP_CLR-1:0]};
  endfunction

  assign masked = clr_top(ea);
  assign raddr  = ea[ADDR_W-1] ? masked : (masked | rm_offset);
endmodule

// File: rtl/eaq_fault.sv
module eaq_fault import eaq_pkg::*; (
  input  logic       fault,
  input  logic [1:0] acc,
  output exc_e       exc,
  output logic       dar_we
);
  always_comb begin
    exc    = EXC_NONE;
    dar_we = 1'b0;
    if (fault) begin
      if (acc == ACC_FETCH) exc = EXC_ISEG;
      else begin
        exc    = EXC_DSEG;
        dar_we = 1'b1;
      end
    end
  end
endmodule

// File: rtl/eaq_qualifier.sv
module eaq_qualifier import eaq_pkg::*; #(
  parameter int ADDR_W     = 64,
  parameter int LPID_W     = 12,
  parameter int PID_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int PS_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] ea,
  input  logic              hv_mode,
  input  logic              reloc,
  input  logic [1:0]        acc,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [ADDR_W-1:0] rm_offset,
  output logic              done,
  output logic              id_valid,
  output logic [LPID_W-1:0] lpid_o,
  output logic [PID_W-1:0]  pid_o,
  output logic              real_mode,
  output logic              part_only,
  output logic [ADDR_W-1:0] real_addr,
  output logic [2:0]        perm_rwx,
  output logic [PS_W-1:0]   page_shift,
  output logic              seg_fault,
  output logic [1:0]        exc_class,
  output logic [ADDR_W-1:0] fault_dar,
  output logic              err_clr
);
  localparam logic [PS_W-1:0] PS_VAL = PS_W'(PAGE_SHIFT);

  logic              dec_legal;
  logic [LPID_W-1:0] dec_lpid;
  logic [PID_W-1:0]  dec_pid;
  logic [ADDR_W-1:0] ea_masked, rm_addr;
  exc_e              n_exc;
  logic              dar_we;

  logic path_rm, path_po, path_vm;
  logic n_fault, n_idv;
  logic [LPID_W-1:0] n_lpid;
  logic [PID_W-1:0]  n_pid;
  logic [ADDR_W-1:0] n_raddr;

  eaq_decode #(.ADDR_W(ADDR_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_dec (
    .ea(ea), .hv_mode(hv_mode), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
    .legal(dec_legal), .lpid(dec_lpid), .pid(dec_pid)
  );

  eaq_realmode #(.ADDR_W(ADDR_W)) u_rm (
    .ea(ea), .rm_offset(rm_offset), .masked(ea_masked), .raddr(rm_addr)
  );

  assign path_rm = hv_mode && !reloc;
  assign path_po = !hv_mode && !reloc;
  assign path_vm = reloc;
  assign n_fault = path_vm && !dec_legal;
  assign n_idv   = (path_vm && dec_legal) || path_po;
  assign n_lpid  = path_vm ? dec_lpid : (path_po ? lpid_reg : '0);
  assign n_pid   = path_vm ? dec_pid : '0;
  assign n_raddr = path_rm ? rm_addr : (path_po ? ea_masked : '0);

  eaq_fault u_flt (.fault(n_fault), .acc(acc), .exc(n_exc), .dar_we(dar_we));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      id_valid   <= 1'b0;
      lpid_o     <= '0;
      pid_o      <= '0;
      real_mode  <= 1'b0;
      part_only  <= 1'b0;
      real_addr  <= '0;
      perm_rwx   <= '0;
      page_shift <= '0;
      seg_fault  <= 1'b0;
      exc_class  <= '0;
      fault_dar  <= '0;
      err_clr    <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        id_valid   <= n_idv;
        lpid_o     <= n_lpid;
        pid_o      <= n_pid;
        real_mode  <= path_rm;
        part_only  <= path_po;
        real_addr  <= n_raddr;
        perm_rwx   <= path_rm ? 3'b111 : 3'b000;
        page_shift <= path_rm ? PS_VAL : '0;
        seg_fault  <= n_fault;
        exc_class  <= n_exc;
        err_clr    <= n_fault;
        if (dar_we) fault_dar <= ea;
      end
    end
  end

  a_r1_rsvd_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req && reloc && (|ea[ADDR_W-3 -: RSVD_BITS])) |=> (seg_fault && !id_valid));
  a_r3_fault_no_ids: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fault |-> (!id_valid && lpid_o == '0 && pid_o == '0));
  a_r4_class_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fault |-> (exc_class != 2'd0));
  a_r5_dar_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc_class != 2'd2) |-> $stable(fault_dar));
  a_r8_rm_perms: assert property (@(posedge clk) disable iff (!rst_n)
    real_mode |-> (perm_rwx == 3'b111 && !seg_fault));
  a_r10_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable({id_valid, lpid_o, pid_o, real_addr, seg_fault, exc_class, fault_dar}));
endmodule

// File: tb/eaq_qualifier_tb.sv
module eaq_qualifier_tb;
  localparam int AW = 64, LW = 8, PW = 16, PSH = 12, PSW = 8;

  logic clk = 0, rst_n = 0, req = 0, hv = 0, rl = 0;
  logic [AW-1:0] ea = '0, off = '0;
  logic [1:0] acc = '0;
  logic [LW-1:0] lp = '0;
  logic [PW-1:0] pd = '0;
  logic done, idv, rm, po, sf, ec;
  logic [LW-1:0] lpo;
  logic [PW-1:0] pdo;
  logic [AW-1:0] ra, dar;
  logic [2:0] perm;
  logic [PSW-1:0] psh;
  logic [1:0] exc;

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_dar = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  eaq_qualifier #(.ADDR_W(AW), .LPID_W(LW), .PID_W(PW), .PAGE_SHIFT(PSH), .PS_W(PSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ea(ea), .hv_mode(hv), .reloc(rl), .acc(acc),
    .lpid_reg(lp), .pid_reg(pd), .rm_offset(off), .done(done), .id_valid(idv),
    .lpid_o(lpo), .pid_o(pdo), .real_mode(rm), .part_only(po), .real_addr(ra),
    .perm_rwx(perm), .page_shift(psh), .seg_fault(sf), .exc_class(exc),
    .fault_dar(dar), .err_clr(ec)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic run(input logic [AW-1:0] a, input logic h, input logic r, input logic [1:0] ac,
                     input logic [LW-1:0] l, input logic [PW-1:0] p, input logic [AW-1:0] o);
    logic [1:0] q;
    logic bad, f, v;
    logic [LW-1:0] el;
    logic [PW-1:0] ep;
    logic [AW-1:0] er;
    logic [1:0] ex;
    @(negedge clk);
    ea = a; hv = h; rl = r; acc = ac; lp = l; pd = p; off = o; req = 1;
    q = a[63:62];
    bad = ((a >> 52) & 64'h3FF) != 0;
    f = 0; v = 0; el = 0; ep = 0; er = 0;
    if (!r) begin
      if (h) er = (a & 64'h0FFF_FFFF_FFFF_FFFF) | (a[63] ? 64'd0 : o);
      else begin v = 1; el = l; er = a & 64'h0FFF_FFFF_FFFF_FFFF; end
    end else if (bad) f = 1;
    else if (h) begin
      v = 1;
      if (q == 2'd1 || q == 2'd2) el = l;
      if (q == 2'd0 || q == 2'd1) ep = p;
    end else if (q == 2'd0) begin v = 1; el = l; ep = p; end
    else if (q == 2'd3) begin v = 1; el = l; end
    else f = 1;
    ex = !f ? 2'd0 : (ac == 2'b10 ? 2'd1 : 2'd2);
    if (ex == 2'd2) exp_dar = a;
    @(negedge clk);
    req = 0;
    chk("R10 done", AW'(done), 1);
    chk("R1 R3 seg_fault", AW'(sf), AW'(f));
    chk("R2 R3 R9 id_valid", AW'(idv), AW'(v));
    chk("R2 R3 lpid", AW'(lpo), AW'(el));
    chk("R2 R3 pid", AW'(pdo), AW'(ep));
    chk("R7 R9 real_addr", ra, er);
    chk("R8 real_mode", AW'(rm), AW'(h && !r));
    chk("R9 part_only", AW'(po), AW'(!h && !r));
    chk("R8 perm", AW'(perm), (h && !r) ? 7 : 0);
    chk("R8 page_shift", AW'(psh), (h && !r) ? PSH : 0);
    chk("R4 exc_class", AW'(exc), AW'(ex));
    chk("R5 fault_dar", dar, exp_dar);
    chk("R6 err_clr", AW'(ec), AW'(f));
    @(negedge clk);
    chk("R10 done one cycle", AW'(done), 0);
    chk("R10 hold", {ra[AW-1:LW+PW+2], lpo, pdo, sf, idv}, {er[AW-1:LW+PW+2], el, ep, f, v});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R11 reset done", AW'(done), 0);
    chk("R11 reset outputs", {ra[AW-1:8], lpo, idv, sf, rm, po, perm, exc, ec}, '0);
    chk("R11 reset dar", dar, 0);
    rst_n = 1;
    for (int qq = 0; qq < 4; qq++) begin
      run({2'(qq), 62'h1234}, 1, 1, 2'b00, 8'hA5, 16'hBEEF, '0);
      run({2'(qq), 62'h5678}, 0, 1, 2'b01, 8'hFF, 16'hFFFF, '0);
    end
    run(64'h2000_0000_0000_0000, 1, 1, 2'b00, 8'h11, 16'h22, '0);
    run(64'h0010_0000_0000_0000, 1, 1, 2'b10, 8'h11, 16'h22, '0);
    run(64'h4000_0000_0000_0040, 0, 1, 2'b01, 8'h3, 16'h4, '0);
    run(64'h8000_0000_0000_0080, 0, 1, 2'b11, 8'h3, 16'h4, '0);
    run(64'h4000_0000_0000_0100, 0, 1, 2'b10, 8'h3, 16'h4, '0);
    run(64'h7230_0000_0000_1000, 1, 0, 2'b00, 8'h1, 16'h1, 64'h0000_0040_0000_0000);
    run(64'hF230_0000_0000_1000, 1, 0, 2'b10, 8'h1, 16'h1, 64'h0000_0040_0000_0000);
    run(64'h7FF0_0000_0000_2000, 0, 0, 2'b01, 8'h77, 16'h99, '0);
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = {$urandom, $urandom};
      if ($urandom % 2) a[61:52] = '0;
      run(a, 1'($urandom), ($urandom % 4) != 0, 2'($urandom), 8'($urandom), 16'($urandom),
          {$urandom, $urandom});
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule